// File: doc/BRIEF.md
# UART FIFO Status and Flag Register

This block is the status byte that sits beside a UART's transmit and receive FIFOs. It takes the occupancy count of each FIFO, along with a strobe for every host write into the transmit FIFO and every host read from the receive FIFO. From these it builds an 8-bit status value that the host can read or write at any time. Two bits show whether each FIFO is empty. Two sticky bits record host misuse: a write into a full transmit FIFO, or a read from an empty receive FIFO.

The empty bits come only from the FIFO occupancy counts. A character still being shifted in or out does not change them. The two sticky bits are always recorded, whatever the interrupt enables say. The host clears a sticky bit by writing a one to its position. Each sticky bit is ANDed with its own enable, and the two results are ORed into a single level-sensitive interrupt request.

Top module: `uart_fifo_flags`

## Requirements
- R1: While reset is held and both FIFOs are empty, the status byte reads 0xC0 and the interrupt output is 0.
- R2: Bit 7 reads 1 exactly when the transmit occupancy input is 0, in the same cycle, with no regard to any character in the shift path.
- R3: Bit 6 reads 1 exactly when the receive occupancy input is 0, in the same cycle.
- R4: Bits 5 down to 2 always read 0.
- R5: A transmit push while the transmit occupancy equals TX_DEPTH sets bit 1, whatever the overflow interrupt enable is. A push at any lower occupancy leaves bit 1 at 0.
- R6: A receive pop while the receive occupancy is 0 sets bit 0, whatever the underflow interrupt enable is. A pop at non-zero occupancy leaves bit 0 at 0.
- R7: A host write with a 1 in bit 1 or bit 0 clears that sticky bit on the next clock. A 0 in that position leaves the bit as it was.
- R8: If a set event and a write-1-to-clear hit the same sticky bit on the same clock, the bit ends up set.
- R9: Host writes to bits 7 down to 2 have no effect on the value read back.
- R10: The interrupt output equals (bit 1 AND overflow enable) OR (bit 0 AND underflow enable). It stays high as long as that term holds.
- R11: A sticky bit first reads 1 on the clock after the event that sets it. It never reads 1 during the cycle in which that event is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| tx_level | input | TX_LW | Current transmit FIFO occupancy |
| tx_push | input | 1 | Host write into the transmit FIFO this cycle |
| rx_level | input | RX_LW | Current receive FIFO occupancy |
| rx_pop | input | 1 | Host read from the receive FIFO this cycle |
| host_wr | input | 1 | Host write strobe for the status byte |
| host_wdata | input | 8 | Host write data; bits 1 and 0 are write-1-to-clear |
| host_rdata | output | 8 | Status byte read value |
| tx_ovf_ie | input | 1 | Enable for the transmit overflow interrupt |
| rx_unf_ie | input | 1 | Enable for the receive underflow interrupt |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with TX_DEPTH = 4 and RX_DEPTH = 3. At these depths, every occupancy pair, every push or pop at every occupancy, and every combination of flag and enable can be swept completely. All 256 host write values are applied over pre-set sticky flags, with the occupancies varying, so write-1-to-clear and the inert upper bits are covered in full. The collision between a set event and a clear, and the one-cycle delay before a flag shows, are driven directly at the full and empty boundaries.

// File: rtl/uff_pkg.sv
package uff_pkg;
  // Bit positions inside the status byte; the host decodes these.
  localparam int unsigned POS_TX_EMPTY = 7;
  localparam int unsigned POS_RX_EMPTY = 6;
  localparam int unsigned POS_TX_OVF   = 1;
  localparam int unsigned POS_RX_UNF   = 0;
  localparam int unsigned NUM_STICKY   = 2;

  typedef struct packed {
    logic       tx_empty;
    logic       rx_empty;
    logic [3:0] zero;
    logic       tx_ovf;
    logic       rx_unf;
  } uff_status_t;
endpackage

// File: rtl/uff_occ_mon.sv
module uff_occ_mon #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

  always_comb begin
    empty = (level == '0);
    full  = (level == LVL_MAX);
  end

  // R2 R3: the FIFO cannot be empty and full at the same time
  a_r2_empty_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  a_r3_level_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_MAX);
endmodule

// File: rtl/uff_sticky_flag.sv
module uff_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic q
);
  logic q_next;
  logic q_en;

  always_comb begin
    q_en   = set_ev | clr_ev;
    q_next = set_ev ? 1'b1 : 1'b0;   // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_next;
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> q);
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !q);
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_ev && !set_ev) |=> $stable(q));
endmodule

// File: rtl/uart_fifo_flags.sv
module uart_fifo_flags #(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16,
  localparam int unsigned TX_LW = $clog2(TX_DEPTH + 1),
  localparam int unsigned RX_LW = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TX_LW-1:0] tx_level,
  input  logic             tx_push,
  input  logic [RX_LW-1:0] rx_level,
  input  logic             rx_pop,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             tx_ovf_ie,
  input  logic             rx_unf_ie,
  output logic             irq
);
  import uff_pkg::*;

  localparam int unsigned NS = NUM_STICKY;

  // Reset: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Occupancy decode
  logic tx_empty, tx_full, rx_empty, rx_full;

  uff_occ_mon #(.DEPTH(TX_DEPTH)) u_tx_occ (
    .clk(clk), .rst_n(rst_core_n), .level(tx_level),
    .empty(tx_empty), .full(tx_full)
  );
  uff_occ_mon #(.DEPTH(RX_DEPTH)) u_rx_occ (
    .clk(clk), .rst_n(rst_core_n), .level(rx_level),
    .empty(rx_empty), .full(rx_full)
  );

  // Sticky flags: index 1 = transmit overflow, index 0 = receive underflow
  logic [NS-1:0] set_vec, clr_vec, flag_q, ie_vec;

  always_comb begin
    set_vec[POS_TX_OVF] = tx_push & tx_full;
    set_vec[POS_RX_UNF] = rx_pop  & rx_empty;
    clr_vec = {NS{host_wr}} & host_wdata[NS-1:0];
    ie_vec[POS_TX_OVF] = tx_ovf_ie;
    ie_vec[POS_RX_UNF] = rx_unf_ie;
  end

  for (genvar g = 0; g < NS; g++) begin : g_flag
    uff_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_core_n),
      .set_ev(set_vec[g]), .clr_ev(clr_vec[g]), .q(flag_q[g])
    );
  end

  // Read path and interrupt
  uff_status_t stat;

  always_comb begin
    stat          = '0;
    stat.tx_empty = tx_empty;
    stat.rx_empty = rx_empty;
    stat.tx_ovf   = flag_q[POS_TX_OVF];
    stat.rx_unf   = flag_q[POS_RX_UNF];
    host_rdata    = stat;
    irq           = |(flag_q & ie_vec);
  end

  a_r5_ovf_sets: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tx_push && tx_level == TX_LW'(TX_DEPTH)) |=> host_rdata[1]);
  a_r6_unf_sets: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rx_pop && rx_level == '0) |=> host_rdata[0]);
  a_r6_rx_full_nonempty: assert property (@(posedge clk) disable iff (!rst_core_n)
    rx_full |-> !host_rdata[6]);
  a_r10_irq_off_disabled: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!tx_ovf_ie && !rx_unf_ie) |-> !irq);
  a_r9_hi_write_inert: assert property (@(posedge clk) disable iff (!rst_core_n)
    (host_wr && host_wdata[7:2] != '0) |=> host_rdata[5:2] == 4'h0);
  a_r11_no_early_flag: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!host_rdata[1] && !(tx_push && tx_level == TX_LW'(TX_DEPTH))) |=> !host_rdata[1]);
endmodule

// File: tb/uart_fifo_flags_tb.sv
module uart_fifo_flags_tb_top;
  localparam int TXD = 4;
  localparam int RXD = 3;
  localparam int TLW = $clog2(TXD + 1);
  localparam int RLW = $clog2(RXD + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic [TLW-1:0] tx_level;
  logic           tx_push;
  logic [RLW-1:0] rx_level;
  logic           rx_pop;
  logic           host_wr;
  logic [7:0]     host_wdata;
  logic [7:0]     host_rdata;
  logic           tx_ovf_ie, rx_unf_ie, irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  uart_fifo_flags #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_push(tx_push),
    .rx_level(rx_level), .rx_pop(rx_pop), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_ovf_ie(tx_ovf_ie), .rx_unf_ie(rx_unf_ie), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] status(input int tl, input int rl, input bit ov, input bit un);
    return {tl == 0, rl == 0, 4'b0000, ov, un};
  endfunction

  task automatic clear_all();
    host_wr = 1'b1; host_wdata = 8'h03; tick(); host_wr = 1'b0; host_wdata = 8'h00;
  endtask

  initial begin
    rst_n = 1'b0; tx_level = '0; rx_level = '0; tx_push = 1'b0; rx_pop = 1'b0;
    host_wr = 1'b0; host_wdata = 8'h00; tx_ovf_ie = 1'b0; rx_unf_ie = 1'b0;
    tick(); tick();
    chk("R1 reset byte", host_rdata, 8'hC0);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    tick(); tick(); tick();

    // R2 R3 R4: full occupancy sweep, same-cycle response
    for (int t = 0; t <= TXD; t++)
      for (int r = 0; r <= RXD; r++) begin
        tx_level = TLW'(t); rx_level = RLW'(r); #1;
        chk("R2 R3 R4 empties", host_rdata, status(t, r, 0, 0));
      end
    tx_level = '0; rx_level = '0;

    // R5 R10: push at every occupancy, both enables
    for (int lv = 0; lv <= TXD; lv++)
      for (int ie = 0; ie < 2; ie++) begin
        tx_level = TLW'(lv); tx_ovf_ie = ie[0]; tx_push = 1'b1; #1;
        chk("R11 ovf not yet", {7'b0, host_rdata[1]}, 8'h00);
        tick(); tx_push = 1'b0;
        chk("R5 ovf flag", {7'b0, host_rdata[1]}, {7'b0, lv == TXD});
        chk("R10 ovf irq", {7'b0, irq}, {7'b0, (lv == TXD) && ie == 1});
        tick();
        chk("R10 ovf irq level held", {7'b0, irq}, {7'b0, (lv == TXD) && ie == 1});
        clear_all();
        chk("R7 ovf cleared", host_rdata, status(lv, 0, 0, 0));
      end
    tx_level = '0; tx_ovf_ie = 1'b0;

    // R6 R10: pop at every occupancy, both enables
    for (int lv = 0; lv <= RXD; lv++)
      for (int ie = 0; ie < 2; ie++) begin
        rx_level = RLW'(lv); rx_unf_ie = ie[0]; rx_pop = 1'b1;
        tick(); rx_pop = 1'b0;
        chk("R6 unf flag", {7'b0, host_rdata[0]}, {7'b0, lv == 0});
        chk("R10 unf irq", {7'b0, irq}, {7'b0, lv == 0 && ie == 1});
        clear_all();
        chk("R7 unf cleared", host_rdata, status(0, lv, 0, 0));
      end
    rx_level = '0; rx_unf_ie = 1'b0;

    // R7 R9: every write value over both flags set
    for (int w = 0; w < 256; w++) begin
      tx_level = TLW'(TXD); rx_level = '0; tx_push = 1'b1; rx_pop = 1'b1;
      tick(); tx_push = 1'b0; rx_pop = 1'b0;
      tx_level = TLW'(w % (TXD + 1)); rx_level = RLW'(w % (RXD + 1));
      host_wr = 1'b1; host_wdata = 8'(w);
      tick(); host_wr = 1'b0;
      chk("R7 R9 write response", host_rdata,
          status(w % (TXD + 1), w % (RXD + 1), !w[1], !w[0]));
      clear_all();
    end

    // R8: set and clear collide, from clear and from set state
    for (int pre = 0; pre < 2; pre++) begin
      if (pre == 1) begin
        tx_level = TLW'(TXD); rx_level = '0; tx_push = 1'b1; rx_pop = 1'b1;
        tick(); tx_push = 1'b0; rx_pop = 1'b0;
      end
      tx_level = TLW'(TXD); rx_level = '0; tx_push = 1'b1; rx_pop = 1'b1;
      host_wr = 1'b1; host_wdata = 8'h03;
      tick(); tx_push = 1'b0; rx_pop = 1'b0; host_wr = 1'b0;
      chk("R8 set beats clear", {6'b0, host_rdata[1:0]}, 8'h03);
      clear_all();
    end
    tx_level = '0;

    // R10: every flag and enable combination
    for (int f = 0; f < 4; f++)
      for (int e = 0; e < 4; e++) begin
        tx_level = TLW'(TXD); rx_level = '0;
        tx_push = f[1]; rx_pop = f[0];
        tick(); tx_push = 1'b0; rx_pop = 1'b0;
        tx_ovf_ie = e[1]; rx_unf_ie = e[0]; #1;
        chk("R10 irq gating", {7'b0, irq}, {7'b0, (f & e) != 0});
        tx_ovf_ie = 1'b0; rx_unf_ie = 1'b0;
        clear_all();
      end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule